// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block caches virtual-to-physical page translations in a small fully associative array. Each slot has its own page size, picked from ten sizes between 4 KB and 256 MB. A lookup compares the virtual address against every slot at once. Each slot ignores the address bits that fall inside its own page. The hit flag, a miss flag for a larger next-level buffer, and the physical address all come back in the same cycle the address is presented.

New translations arrive on an insert port. The insert fills the lowest-numbered empty slot. When every slot is occupied, it replaces slots in rotating order. A purge port removes every slot whose page overlaps an address range. The range may be one of the ten page sizes or a 4 GB span, which no slot can hold. If two slots claim the same address, that is a software error; the block reports it on a separate flag.

Top module: `tlb_fa`

## Requirements
- R1: The buffer holds 32 translations; after 32 inserts of distinct 4 KB pages into an empty buffer, every one of them hits.
- R2: Size codes 0..9 select 4K, 8K, 16K, 64K, 256K, 1M, 4M, 16M, 64M and 256M byte pages. A lookup hits a valid slot when the address agrees with the stored virtual address on every bit at or above that page's boundary.
- R3: On a hit, `lk_pa` takes the slot's physical frame bits at and above the page boundary and the lookup address bits below it; bits [11:0] always equal `lk_va[11:0]`.
- R4: On a miss, `lk_hit` is 0, `lk_miss` is 1 and `lk_pa` is all zeros; on a hit, `lk_miss` is 0.
- R5: A lookup is combinational on the current contents. An insert becomes visible to lookups in the cycle after the clock edge that captures it, and not before.
- R6: An insert writes the lowest-numbered invalid slot if any exists. Otherwise it writes the slot named by a rotating pointer. The pointer starts at 0 after reset, advances by one on each insert into a full buffer, and wraps from 31 to 0.
- R7: A purge invalidates every valid slot whose page overlaps the purge range. The test compares the addresses under the mask of the larger of the slot size and the purge size. Purge size codes 0..9 are the page sizes of R2; codes 10..15 mean a 4 GB range.
- R8: `lk_multi` is 1 exactly when two or more slots hit the same lookup address.
- R9: Reset invalidates all slots, so no lookup hits until an insert is made, and it sets the rotating pointer to 0.
- R10: An insert size code above 9 is stored as code 9 (256 MB).
- R11: When a purge and an insert share a cycle, the purge acts on the old contents and the newly inserted slot survives. The victim slot is chosen from the contents before the purge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found none; request for the next level |
| lk_multi | output | 1 | More than one slot matched |
| lk_pa | output | PA_W | Translated physical address, zero on miss |
| ins_en | input | 1 | Write a translation this cycle |
| ins_va | input | VA_W | Virtual address of the new page |
| ins_pa | input | PA_W | Physical address of the new page |
| ins_size | input | 4 | Page size code of the new page |
| pur_en | input | 1 | Purge a range this cycle |
| pur_va | input | VA_W | Address inside the purge range |
| pur_size | input | 4 | Purge range size code |

## Verification
A corrupted stored virtual address or size code shows up at the ports in the very next lookup that touches that page. Depending on the fault, that lookup hits where it should miss, misses where it should hit, or moves the boundary where translated bits hand over to offset bits in `lk_pa`.

A wrong victim pointer stays invisible until a later lookup looks for the slot that was overwritten. The bench therefore fills the buffer, forces wrap-around, and leaves a hole, so that a misplaced victim evicts a known page within two or three inserts. Purge mistakes appear in the first lookup after the purge edge, either as surviving pages inside the range or as lost pages outside it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Bits of every address that are never translated (smallest page).
    localparam int OFFSET_W = 12;

    // Largest size code a stored page may carry.
    localparam logic [3:0] PAGE_CODE_MAX = 4'd9;

    // Map a size code to the bit position of the page boundary.
    // Codes above the page range mean a 4 GB span (purge only).
    function automatic logic [5:0] size_shift(input logic [3:0] code);
        logic [5:0] s;
        case (code)
            4'd0:    s = 6'd12;
            4'd1:    s = 6'd13;
            4'd2:    s = 6'd14;
            4'd3:    s = 6'd16;
            4'd4:    s = 6'd18;
            4'd5:    s = 6'd20;
            4'd6:    s = 6'd22;
            4'd7:    s = 6'd24;
            4'd8:    s = 6'd26;
            4'd9:    s = 6'd28;
            default: s = 6'd32;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tlb_cam_cell.sv
module tlb_cam_cell
    import tlb_pkg::*;
#(
    parameter int VA_W  = 40,
    parameter int PA_W  = 36,
    localparam int VPN_W = VA_W - OFFSET_W,
    localparam int PFN_W = PA_W - OFFSET_W
) (
    input  logic             e_valid,
    input  logic [3:0]       e_size,
    input  logic [VPN_W-1:0] e_vpn,
    input  logic [PFN_W-1:0] e_pfn,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             pur_en,
    input  logic [VA_W-1:0]  pur_va,
    input  logic [3:0]       pur_size,
    output logic             hit,
    output logic             pur_hit,
    output logic [PA_W-1:0]  pa
);

    logic [5:0] sh_e;
    logic [5:0] sh_p;
    logic [5:0] sh_m;
    logic       lk_diff;
    logic       pr_diff;

    always_comb begin
        sh_e    = size_shift(e_size);
        sh_p    = size_shift(pur_size);
        sh_m    = (sh_e > sh_p) ? sh_e : sh_p;
        lk_diff = 1'b0;
        pr_diff = 1'b0;
        for (int b = OFFSET_W; b < VA_W; b++) begin
            if (b >= int'(sh_e)) lk_diff = lk_diff | (lk_va[b] ^ e_vpn[b-OFFSET_W]);
            if (b >= int'(sh_m)) pr_diff = pr_diff | (pur_va[b] ^ e_vpn[b-OFFSET_W]);
        end
        hit     = e_valid & ~lk_diff;
        pur_hit = e_valid & pur_en & ~pr_diff;
    end

    // Translated address: frame above the page boundary, offset below it.
    always_comb begin
        pa = '0;
        if (hit) begin
            pa[OFFSET_W-1:0] = lk_va[OFFSET_W-1:0];
            for (int b = OFFSET_W; b < PA_W; b++) begin
                pa[b] = (b >= int'(sh_e)) ? e_pfn[b-OFFSET_W] : lk_va[b];
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [IDX_W-1:0]   rr_i,
    output logic [IDX_W-1:0]   victim_o,
    output logic               full_o
);

    logic found;

    always_comb begin
        full_o   = &valid_i;
        victim_o = rr_i;
        found    = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_i[i] && !found) begin
                victim_o = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VA_W    = 40,
    parameter int PA_W    = 36
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] lk_va,
    output logic            lk_hit,
    output logic            lk_miss,
    output logic            lk_multi,
    output logic [PA_W-1:0] lk_pa,
    input  logic            ins_en,
    input  logic [VA_W-1:0] ins_va,
    input  logic [PA_W-1:0] ins_pa,
    input  logic [3:0]      ins_size,
    input  logic            pur_en,
    input  logic [VA_W-1:0] pur_va,
    input  logic [3:0]      pur_size
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int VPN_W = VA_W - OFFSET_W;
    localparam int PFN_W = PA_W - OFFSET_W;

    typedef struct packed {
        logic             valid;
        logic [3:0]       size;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic  [IDX_W-1:0]   rr;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] pur_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic [PA_W-1:0]    cell_pa [ENTRIES];
    logic [IDX_W-1:0]   victim;
    logic               full;
    logic [PA_W-1:0]    pa_or;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        assign valid_vec[g] = st_q.slot[g].valid;
        tlb_cam_cell #(.VA_W(VA_W), .PA_W(PA_W)) u_cell (
            .e_valid  (st_q.slot[g].valid),
            .e_size   (st_q.slot[g].size),
            .e_vpn    (st_q.slot[g].vpn),
            .e_pfn    (st_q.slot[g].pfn),
            .lk_va    (lk_va),
            .pur_en   (pur_en),
            .pur_va   (pur_va),
            .pur_size (pur_size),
            .hit      (hit_vec[g]),
            .pur_hit  (pur_vec[g]),
            .pa       (cell_pa[g])
        );
    end

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_i  (valid_vec),
        .rr_i     (st_q.rr),
        .victim_o (victim),
        .full_o   (full)
    );

    always_comb begin
        pa_or = '0;
        for (int i = 0; i < ENTRIES; i++) pa_or = pa_or | cell_pa[i];
    end

    assign lk_hit   = |hit_vec;
    assign lk_miss  = ~lk_hit;
    assign lk_multi = ($countones(hit_vec) > 1);
    assign lk_pa    = pa_or;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (pur_vec[i]) st_d.slot[i].valid = 1'b0;
        end
        if (ins_en) begin
            st_d.slot[victim].valid = 1'b1;
            st_d.slot[victim].size  = (ins_size > PAGE_CODE_MAX) ? PAGE_CODE_MAX : ins_size;
            st_d.slot[victim].vpn   = ins_va[VA_W-1:OFFSET_W];
            st_d.slot[victim].pfn   = ins_pa[PA_W-1:OFFSET_W];
            if (full) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES-1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int VA_W = 40,
    parameter int PA_W = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic [VA_W-1:0] lk_va,
    input logic            lk_hit,
    input logic            lk_multi,
    input logic [PA_W-1:0] lk_pa,
    input logic            ins_en,
    input logic [VA_W-1:0] ins_va,
    input logic            pur_en,
    input logic [VA_W-1:0] pur_va
);

    // R4
    miss_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

    // R8
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    // R9
    empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // R7
    purged_addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pur_en && !ins_en) |=> !(lk_hit && (lk_va == $past(pur_va))));

    // R5
    inserted_addr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !pur_en) |=> ((lk_va != $past(ins_va)) || lk_hit));

endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_va    (lk_va),
    .lk_hit   (lk_hit),
    .lk_multi (lk_multi),
    .lk_pa    (lk_pa),
    .ins_en   (ins_en),
    .ins_va   (ins_va),
    .pur_en   (pur_en),
    .pur_va   (pur_va)
);

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;

    localparam int VA_W = 40;
    localparam int PA_W = 36;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [VA_W-1:0] lk_va;
    logic            lk_hit, lk_miss, lk_multi;
    logic [PA_W-1:0] lk_pa;
    logic            ins_en;
    logic [VA_W-1:0] ins_va;
    logic [PA_W-1:0] ins_pa;
    logic [3:0]      ins_size;
    logic            pur_en;
    logic [VA_W-1:0] pur_va;
    logic [3:0]      pur_size;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    tlb_fa #(.ENTRIES(32), .VA_W(VA_W), .PA_W(PA_W)) u_tlb_fa (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit),
        .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_pa(lk_pa),
        .ins_en(ins_en), .ins_va(ins_va), .ins_pa(ins_pa), .ins_size(ins_size),
        .pur_en(pur_en), .pur_va(pur_va), .pur_size(pur_size)
    );

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic            hit;
        logic [PA_W-1:0] pa;
    } vec_t;

    // Pages set up first: 4K @0x00_1234_5000, 256M @0x00_4000_0000,
    // 64K @0x01_0008_0000, 1M @0x02_0030_0000.
    localparam vec_t VECS [9] = '{
        '{40'h00_1234_5ABC, 1'b1, 36'h0_ABCD_EABC},
        '{40'h00_1234_6000, 1'b0, 36'h0},
        '{40'h00_4ABC_DEF0, 1'b1, 36'h9_0ABC_DEF0},
        '{40'h00_5000_0000, 1'b0, 36'h0},
        '{40'h01_0008_FFFF, 1'b1, 36'h3_0001_FFFF},
        '{40'h01_0009_0000, 1'b0, 36'h0},
        '{40'h02_003F_FFFF, 1'b1, 36'h4_560F_FFFF},
        '{40'h02_0040_0000, 1'b0, 36'h0},
        '{40'h00_0000_0000, 1'b0, 36'h0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic look(input string tag, input logic [VA_W-1:0] va,
                        input logic eh, input logic [PA_W-1:0] epa);
        @(negedge clk);
        lk_va = va;
        #1;
        chk({tag, " hit"},  64'(lk_hit),  64'(eh));
        chk({tag, " miss R4"}, 64'(lk_miss), 64'(!eh));
        chk({tag, " pa"},   64'(lk_pa),   eh ? 64'(epa) : 64'h0);
    endtask

    task automatic op(input logic ie, input logic [VA_W-1:0] iva,
                      input logic [PA_W-1:0] ipa, input logic [3:0] isz,
                      input logic pe, input logic [VA_W-1:0] pva, input logic [3:0] psz);
        @(negedge clk);
        ins_en = ie; ins_va = iva; ins_pa = ipa; ins_size = isz;
        pur_en = pe; pur_va = pva; pur_size = psz;
        @(posedge clk);
        #1;
        ins_en = 1'b0; pur_en = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_va = '0; ins_en = 1'b0; ins_va = '0; ins_pa = '0;
        ins_size = '0; pur_en = 1'b0; pur_va = '0; pur_size = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset hit", 64'(lk_hit), 64'h0);
        chk("R9 reset multi", 64'(lk_multi), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        look("R9 empty after reset", 40'h0, 1'b0, '0);

        op(1, 40'h00_1234_5000, 36'h0_ABCD_E000, 4'd0, 0, '0, '0);
        op(1, 40'h00_4000_0000, 36'h9_0000_0000, 4'd9, 0, '0, '0);
        op(1, 40'h01_0008_0000, 36'h3_0001_0000, 4'd3, 0, '0, '0);
        op(1, 40'h02_0030_0000, 36'h4_5600_0000, 4'd5, 0, '0, '0);

        // R2 R3 R4: walk the vector table
        for (int k = 0; k < 9; k++) begin
            look($sformatf("R2/R3 vec%0d", k), VECS[k].va, VECS[k].hit, VECS[k].pa);
        end

        // R8: small page inside the 256M page -> two hits
        op(1, 40'h00_4100_0000, 36'h1_0000_0000, 4'd0, 0, '0, '0);
        look("R8 overlap", 40'h00_4100_0010, 1'b1, 36'h1_0000_0010 | 36'h9_0100_0010);
        chk("R8 multi set", 64'(lk_multi), 64'h1);
        look("R8 single", 40'h00_1234_5000, 1'b1, 36'h0_ABCD_E000);
        chk("R8 multi clear", 64'(lk_multi), 64'h0);

        // R7: 4K purge also removes the 256M page that covers it
        op(0, '0, '0, '0, 1, 40'h00_4100_0000, 4'd0);
        look("R7 small purge kills large", 40'h00_4ABC_DEF0, 1'b0, '0);
        look("R7 small purge kills small", 40'h00_4100_0010, 1'b0, '0);
        look("R7 unrelated kept", 40'h00_1234_5ABC, 1'b1, 36'h0_ABCD_EABC);

        // R7: 4 GB purge (code 10) at 0x01_xxxx_xxxx
        op(0, '0, '0, '0, 1, 40'h01_0000_0000, 4'd10);
        look("R7 4G purge inside", 40'h01_0008_0000, 1'b0, '0);
        look("R7 4G purge outside", 40'h02_003F_FFFF, 1'b1, 36'h4_560F_FFFF);

        // R10: code 12 stored as 256M
        op(1, 40'h05_0000_0000, 36'h7_0000_0000, 4'd12, 0, '0, '0);
        look("R10 clamp inside", 40'h05_0FFF_FFFF, 1'b1, 36'h7_0FFF_FFFF);
        look("R10 clamp beyond 256M", 40'h05_1000_0000, 1'b0, '0);

        // R11 + R5: purge and insert share a cycle; lookup during insert
        @(negedge clk);
        ins_en = 1; ins_va = 40'h06_0000_0000; ins_pa = 36'h1_2345_6000; ins_size = 4'd0;
        pur_en = 1; pur_va = 40'h05_0000_0000; pur_size = 4'd10;
        lk_va = 40'h06_0000_0ABC;
        #1;
        chk("R5 not visible before edge", 64'(lk_hit), 64'h0);
        @(posedge clk);
        #1;
        ins_en = 1'b0; pur_en = 1'b0;
        chk("R5 visible after edge", 64'(lk_hit), 64'h1);
        look("R11 inserted survives", 40'h06_0000_0ABC, 1'b1, 36'h1_2345_6ABC);
        look("R11 purge applied", 40'h05_0000_0000, 1'b0, '0);

        // R9: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look("R9 cleared", 40'h00_1234_5ABC, 1'b0, '0);

        // R1: fill all 32 slots with 4K pages (slot i holds (i+1)<<12)
        for (int i = 0; i < 32; i++) begin
            op(1, 40'((i + 1) << 12), 36'h2_0000_0000 + 36'(i << 12), 4'd0, 0, '0, '0);
        end
        for (int i = 0; i < 32; i++) begin
            look($sformatf("R1 slot%0d", i), 40'((i + 1) << 12) | 40'h123,
                 1'b1, 36'h2_0000_0000 + 36'(i << 12) + 36'h123);
        end

        // R6: full -> rotating pointer from slot 0
        op(1, 40'h7F000, 36'h3_0000_0000, 4'd0, 0, '0, '0);
        look("R6 slot0 replaced", 40'h01000, 1'b0, '0);
        look("R6 slot1 kept", 40'h02000, 1'b1, 36'h2_0000_1000);
        look("R6 new page", 40'h7F000, 1'b1, 36'h3_0000_0000);
        op(1, 40'h80000, 36'h3_0000_1000, 4'd0, 0, '0, '0);
        look("R6 slot1 replaced", 40'h02000, 1'b0, '0);
        // hole in slot 5 must be filled before pointer slot 2
        op(0, '0, '0, '0, 1, 40'h06000, 4'd0);
        op(1, 40'h81000, 36'h3_0000_2000, 4'd0, 0, '0, '0);
        look("R6 invalid preferred", 40'h03000, 1'b1, 36'h2_0000_2000);
        look("R6 hole filled", 40'h81000, 1'b1, 36'h3_0000_2000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule